// File: doc/BRIEF.md
# Halfword-granular instruction fetch unit

This unit fetches a single instruction for a core that may run 16-bit compressed code alongside 32-bit base code. The caller pulses `start` with a program counter and a flag that says whether compressed code is allowed. The unit first checks the alignment of that address. It then fetches the low halfword: it translates the PC through a translation port and reads 16 bits through an instruction-memory port. It looks at the two lowest bits of that halfword to decide whether a second halfword is needed.

For a 32-bit instruction, the unit translates PC+2 on its own and reads that halfword as well. Because of this, a fault on the upper half reports the exact faulting address, PC+2. A single-cycle `done` pulse closes every fetch. The pulse carries one of three results: a base instruction, a compressed instruction, or an exception with a cause code and a fault address. It also carries the distance by which the sequential PC advances.

Both ports use a valid/ready request, followed by a response that is a valid pulse. The response may come at the earliest in the cycle after the request is accepted.

Top module: `ifetch_granule`

## Requirements
- R1: If `pc[0]` is 1, or `pc[1]` is 1 while `c_ena` is 0, the result is an error (`res_kind`=3) with cause 0 and `res_tval`=PC. No translation request and no memory request are issued.
- R2: The low halfword is fetched by translating PC. If that translation faults, the result is an error. Its cause is the `xl_rsp_cause` value passed through unchanged, and `res_tval`=PC. No memory request is issued.
- R3: A memory error on the low-halfword read gives an error with cause 1 and `res_tval`=PC.
- R4: If the low halfword has bits [1:0] other than 2'b11, the result is compressed (`res_kind`=2). `res_instr` is {16'h0, halfword} and `res_step`=2. Exactly one translation and one memory read are made.
- R5: If the low halfword has bits [1:0]=2'b11, the second translation request carries PC+2. Its translated address is then read.
- R6: A translation fault on the second halfword gives an error with the port's cause and `res_tval`=PC+2. A memory error on the second halfword gives cause 1 and `res_tval`=PC+2.
- R7: A base result (`res_kind`=1) has `res_instr`={upper halfword, lower halfword} and `res_step`=4. Error results have `res_step`=0, `res_instr`=0 and `res_tval` set as above. Non-error results have cause 0 and `res_tval`=0.
- R8: `done` is high for exactly one cycle per accepted start. A `start` that arrives while a fetch is in progress is ignored, and so is one that arrives in the `done` cycle. The results stay unchanged until the next accepted start.
- R9: A synchronous `rst` returns the unit to idle. It drops any outstanding request, so both request valids and `done` are low and `res_kind` is 0. Responses that come later are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a fetch (accepted only when idle) |
| pc | input | XLEN | Fetch address |
| c_ena | input | 1 | Compressed instructions allowed |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translation request accepted |
| xl_req_vaddr | output | XLEN | Virtual address to translate |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_cause | input | 5 | Cause code for a failed translation |
| xl_rsp_paddr | input | XLEN | Translated address |
| mem_req_valid | output | 1 | Halfword read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | XLEN | Physical halfword address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 16 | Halfword read data |
| done | output | 1 | One-cycle completion pulse |
| res_kind | output | 2 | 0 none, 1 base, 2 compressed, 3 error |
| res_instr | output | 32 | Fetched instruction |
| res_cause | output | 5 | Exception cause |
| res_tval | output | XLEN | Faulting address |
| res_step | output | 3 | PC advance: 4, 2 or 0 |

## Verification
Two events can fall in the same cycle: a new `start` and a fetch that is still running, or a new `start` and the `done` pulse of the fetch just ending. The bench raises `start` with a different PC a few cycles into a fetch. It also raises `start` in the very cycle where `done` is seen. In both cases it expects the result to belong to the first PC, and it expects no further `done` pulse or request during a quiet window afterwards. Random fetches place translation faults and memory errors at PC or at PC+2, and a bench function predicts each outcome.

// File: rtl/ifetch_granule.sv
module ifetch_granule #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] pc,
  input  logic            c_ena,
  output logic            xl_req_valid,
  input  logic            xl_req_ready,
  output logic [XLEN-1:0] xl_req_vaddr,
  input  logic            xl_rsp_valid,
  input  logic            xl_rsp_fault,
  input  logic [4:0]      xl_rsp_cause,
  input  logic [XLEN-1:0] xl_rsp_paddr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [15:0]     mem_rsp_data,
  output logic            done,
  output logic [1:0]      res_kind,
  output logic [31:0]     res_instr,
  output logic [4:0]      res_cause,
  output logic [XLEN-1:0] res_tval,
  output logic [2:0]      res_step
);
  localparam logic [1:0] K_NONE = 2'd0, K_BASE = 2'd1, K_CMP = 2'd2, K_ERR = 2'd3;
  localparam logic [4:0] C_MISALIGN = 5'd0, C_ACCESS = 5'd1;

  typedef enum logic [2:0] {S_IDLE, S_XLATE_LO, S_READ_LO, S_XLATE_HI, S_READ_HI, S_DONE} state_t;

  state_t          state;
  logic            sent;
  logic [XLEN-1:0] pc_r, pa;
  logic [15:0]     lo;

  wire [XLEN-1:0] pc_hi    = pc_r + XLEN'(2);
  wire            misalign = pc[0] | (pc[1] & ~c_ena);
  wire            in_xl    = (state == S_XLATE_LO) | (state == S_XLATE_HI);
  wire            in_rd    = (state == S_READ_LO) | (state == S_READ_HI);
  wire [XLEN-1:0] cur_va   = (state == S_XLATE_HI || state == S_READ_HI) ? pc_hi : pc_r;

  assign xl_req_valid  = in_xl & ~sent;
  assign xl_req_vaddr  = cur_va;
  assign mem_req_valid = in_rd & ~sent;
  assign mem_req_addr  = pa;
  assign done          = (state == S_DONE);
  assign res_step      = (res_kind == K_BASE) ? 3'd4 : (res_kind == K_CMP) ? 3'd2 : 3'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sent      <= 1'b0;
      pc_r      <= '0;
      pa        <= '0;
      lo        <= '0;
      res_kind  <= K_NONE;
      res_instr <= '0;
      res_cause <= '0;
      res_tval  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc_r <= pc;
          sent <= 1'b0;
          if (misalign) begin
            res_kind  <= K_ERR;
            res_instr <= '0;
            res_cause <= C_MISALIGN;
            res_tval  <= pc;
            state     <= S_DONE;
          end else begin
            state <= S_XLATE_LO;
          end
        end
        S_XLATE_LO, S_XLATE_HI: begin
          if (!sent && xl_req_ready) sent <= 1'b1;
          if (sent && xl_rsp_valid) begin
            sent <= 1'b0;
            if (xl_rsp_fault) begin
              res_kind  <= K_ERR;
              res_instr <= '0;
              res_cause <= xl_rsp_cause;
              res_tval  <= cur_va;
              state     <= S_DONE;
            end else begin
              pa    <= xl_rsp_paddr;
              state <= (state == S_XLATE_LO) ? S_READ_LO : S_READ_HI;
            end
          end
        end
        S_READ_LO, S_READ_HI: begin
          if (!sent && mem_req_ready) sent <= 1'b1;
          if (sent && mem_rsp_valid) begin
            sent <= 1'b0;
            if (mem_rsp_err) begin
              res_kind  <= K_ERR;
              res_instr <= '0;
              res_cause <= C_ACCESS;
              res_tval  <= cur_va;
              state     <= S_DONE;
            end else if (state == S_READ_HI) begin
              res_kind  <= K_BASE;
              res_instr <= {mem_rsp_data, lo};
              res_cause <= '0;
              res_tval  <= '0;
              state     <= S_DONE;
            end else if (mem_rsp_data[1:0] != 2'b11) begin
              res_kind  <= K_CMP;
              res_instr <= {16'h0, mem_rsp_data};
              res_cause <= '0;
              res_tval  <= '0;
              state     <= S_DONE;
            end else begin
              lo    <= mem_rsp_data;
              state <= S_XLATE_HI;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_misalign_done_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && misalign) |=> (done && res_kind == K_ERR && res_cause == C_MISALIGN && !xl_req_valid && !mem_req_valid));

  p_cmp_form_r4: assert property (@(posedge clk) disable iff (rst)
    (done && res_kind == K_CMP) |-> (res_step == 3'd2 && res_instr[1:0] != 2'b11 && res_instr[31:16] == 16'h0));

  p_hi_vaddr_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_XLATE_HI && xl_req_valid) |-> (xl_req_vaddr == pc_r + XLEN'(2)));

  p_base_form_r7: assert property (@(posedge clk) disable iff (rst)
    (done && res_kind == K_BASE) |-> (res_step == 3'd4 && res_instr[1:0] == 2'b11));

  p_one_port_r5: assert property (@(posedge clk) disable iff (rst)
    !(xl_req_valid && mem_req_valid));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (xl_req_valid && !xl_req_ready) |=> (xl_req_valid && $stable(xl_req_vaddr)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_rst_idle_r9: assert property (@(posedge clk)
    rst |=> (!xl_req_valid && !mem_req_valid && !done && res_kind == K_NONE));
endmodule

// File: tb/test_ifetch_granule.sv
module test_ifetch_granule;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, c_ena = 1'b0;
  logic [31:0] pc = '0;
  logic        xl_req_valid, xl_req_ready = 1'b0, xl_rsp_valid = 1'b0, xl_rsp_fault = 1'b0;
  logic [31:0] xl_req_vaddr, xl_rsp_paddr = '0;
  logic [4:0]  xl_rsp_cause = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  res_kind;
  logic [31:0] res_instr, res_tval;
  logic [4:0]  res_cause;
  logic [2:0]  res_step;

  ifetch_granule #(.XLEN(32)) i_ifetch_granule (
    .clk, .rst, .start, .pc, .c_ena,
    .xl_req_valid, .xl_req_ready, .xl_req_vaddr, .xl_rsp_valid, .xl_rsp_fault, .xl_rsp_cause, .xl_rsp_paddr,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_err, .mem_rsp_data,
    .done, .res_kind, .res_instr, .res_cause, .res_tval, .res_step);

  always #10 clk = ~clk;

  localparam logic [31:0] PA_OFS = 32'h40;
  logic [15:0] marr [64];
  bit          xf_on = 0, me_on = 0;
  logic [31:0] xf_va = '0, me_pa = '0;
  logic [4:0]  xf_cause = 5'd12;
  int          xl_acc = 0, mem_acc = 0, done_cnt = 0, cyc = 0;
  logic [31:0] va2 = '0;
  int          checks = 0, errors = 0;

  bit xp = 0, mp = 0;
  int xd = 0, md = 0;
  logic [31:0] xva = '0, mpa = '0;

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (rst) begin
      xp = 0; mp = 0; xl_req_ready = 0; mem_req_ready = 0; xl_rsp_valid = 0; mem_rsp_valid = 0;
    end else begin
      xl_rsp_valid = 0;
      if (xp) begin
        if (xd == 0) begin
          xl_rsp_valid = 1; xl_rsp_fault = xf_on && (xva == xf_va);
          xl_rsp_cause = xf_cause; xl_rsp_paddr = xva + PA_OFS; xp = 0;
        end else xd--;
      end
      xl_req_ready = 0;
      if (!xp && xl_req_valid && !xl_rsp_valid) begin
        xl_req_ready = ($urandom % 4) != 0;
        if (xl_req_ready) begin
          xp = 1; xd = $urandom % 3; xva = xl_req_vaddr; xl_acc++;
          if (xl_acc == 2) va2 = xl_req_vaddr;
        end
      end
      mem_rsp_valid = 0;
      if (mp) begin
        if (md == 0) begin
          mem_rsp_valid = 1; mem_rsp_err = me_on && (mpa == me_pa);
          mem_rsp_data = marr[mpa[6:1]]; mp = 0;
        end else md--;
      end
      mem_req_ready = 0;
      if (!mp && mem_req_valid && !mem_rsp_valid) begin
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_ready) begin
          mp = 1; md = $urandom % 3; mpa = mem_req_addr; mem_acc++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [1:0]  e_kind;
  logic [31:0] e_instr, e_tval;
  logic [4:0]  e_cause;
  logic [2:0]  e_step;
  int          e_xl, e_mem;
  string       e_tag;

  function automatic logic [15:0] hw_at(input logic [31:0] va);
    logic [31:0] a = va + PA_OFS;
    return marr[a[6:1]];
  endfunction

  task automatic predict(input logic [31:0] p, input bit ce);
    logic [15:0] l, h;
    e_kind = 2'd3; e_instr = '0; e_cause = '0; e_tval = '0; e_step = 3'd0; e_xl = 0; e_mem = 0;
    if (p[0] || (p[1] && !ce)) begin e_tag = "R1"; e_tval = p; return; end
    e_xl = 1;
    if (xf_on && xf_va == p) begin e_tag = "R2"; e_cause = xf_cause; e_tval = p; return; end
    e_mem = 1;
    if (me_on && me_pa == p + PA_OFS) begin e_tag = "R3"; e_cause = 5'd1; e_tval = p; return; end
    l = hw_at(p);
    if (l[1:0] != 2'b11) begin
      e_tag = "R4"; e_kind = 2'd2; e_instr = {16'h0, l}; e_step = 3'd2; return;
    end
    e_xl = 2;
    if (xf_on && xf_va == p + 2) begin e_tag = "R6"; e_cause = xf_cause; e_tval = p + 2; return; end
    e_mem = 2;
    if (me_on && me_pa == p + 2 + PA_OFS) begin e_tag = "R6"; e_cause = 5'd1; e_tval = p + 2; return; end
    h = hw_at(p + 2);
    e_tag = "R7"; e_kind = 2'd1; e_instr = {h, l}; e_step = 3'd4;
  endtask

  task automatic launch(input logic [31:0] p, input bit ce);
    @(negedge clk);
    xl_acc = 0; mem_acc = 0; va2 = '0;
    pc = p; c_ena = ce; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, done, 1'b1);
  endtask

  task automatic judge(input logic [31:0] p, input bit ce);
    predict(p, ce);
    chk({e_tag, " kind"}, res_kind, e_kind);
    chk({e_tag, " instr"}, res_instr, e_instr);
    chk({e_tag, " cause"}, res_cause, e_cause);
    chk({e_tag, " tval"}, res_tval, e_tval);
    chk({e_tag, " step"}, res_step, e_step);
    chk({e_tag, " xlate count"}, xl_acc, e_xl);
    chk({e_tag, " read count"}, mem_acc, e_mem);
    if (e_xl == 2) chk("R5 second vaddr", va2, p + 2);
  endtask

  task automatic run_one(input logic [31:0] p, input bit ce);
    launch(p, ce);
    wait_done("R8");
    judge(p, ce);
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
  endtask

  task automatic quiet(input string tag, input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done || xl_req_valid || mem_req_valid) bad++;
    end
    chk(tag, bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) marr[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    chk("R9 reset kind", res_kind, 2'd0);
    chk("R9 reset outputs", {done, xl_req_valid, mem_req_valid}, 3'b000);
    rst = 0;

    // R1 directed
    run_one(32'h0000_1001, 1'b1);
    run_one(32'h0000_1002, 1'b0);
    // R4: compressed at pc[1]=1 with compressed enabled
    marr[(32'h1002 + PA_OFS) >> 1 & 63] = 16'h4a91;
    run_one(32'h0000_1002, 1'b1);
    // R7 base
    marr[(32'h2000 + PA_OFS) >> 1 & 63] = 16'h0513;
    marr[(32'h2002 + PA_OFS) >> 1 & 63] = 16'h00a0;
    run_one(32'h0000_2000, 1'b0);
    // R2 low translation fault
    xf_on = 1; xf_va = 32'h2000; xf_cause = 5'd12;
    run_one(32'h0000_2000, 1'b0);
    // R6 upper translation fault
    xf_va = 32'h2002; xf_cause = 5'd13;
    run_one(32'h0000_2000, 1'b0);
    xf_on = 0;
    // R3 low memory error, R6 upper memory error
    me_on = 1; me_pa = 32'h2000 + PA_OFS;
    run_one(32'h0000_2000, 1'b0);
    me_pa = 32'h2002 + PA_OFS;
    run_one(32'h0000_2000, 1'b0);
    me_on = 0;

    // R8 start while busy is ignored
    launch(32'h0000_2000, 1'b0);
    @(negedge clk); @(negedge clk);
    if (!done) begin
      pc = 32'h0000_3000; start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_done("R8 busy");
    judge(32'h0000_2000, 1'b0);
    // R8 start in the done cycle is ignored
    pc = 32'h0000_3000; start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 done one cycle after busy start", done, 1'b0);
    done_cnt = 0;
    quiet("R8 no extra fetch", 30);
    chk("R8 no extra done", done_cnt, 0);
    chk("R8 results held", res_instr, 32'h00a0_0513);

    // R9 reset mid-fetch
    launch(32'h0000_2000, 1'b0);
    @(negedge clk);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R9 kind after reset", res_kind, 2'd0);
    quiet("R9 idle after reset", 20);
    run_one(32'h0000_2000, 1'b0);

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [31:0] p;
      bit ce;
      int sel;
      p = $urandom;
      if (($urandom % 4) != 0) p[0] = 1'b0;
      ce = $urandom % 2;
      for (int i = 0; i < 64; i++) marr[i] = 16'($urandom);
      if ($urandom % 2) marr[(p + PA_OFS) >> 1 & 63][1:0] = 2'b11;
      xf_on = 0; me_on = 0;
      sel = $urandom % 6;
      xf_cause = 5'($urandom);
      if (sel == 1) begin xf_on = 1; xf_va = p; end
      if (sel == 2) begin xf_on = 1; xf_va = p + 2; end
      if (sel == 3) begin me_on = 1; me_pa = p + PA_OFS; end
      if (sel == 4) begin me_on = 1; me_pa = p + 2 + PA_OFS; end
      run_one(p, ce);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule